// File: doc/BRIEF.md
# Flash Embedded-Operation Status Reporter

This block produces the status word that a NOR-style flash bank hands back when the host reads it while an embedded program or erase runs. It tracks one bank. A start pulse launches an operation of one of three kinds: single-word program, buffer program or erase. While the operation runs, every status read addressed to this bank returns a word built from a small set of flags. These are a pair of toggle bits, a data-polling bit, a time-limit failure bit and a buffer-abort bit. When the bank is back in a read mode, a status read returns the array data presented on `arr_data`.

The program/erase engine feeds the block a pulse strobe for each internal pulse it fires, a completion strobe and a buffer-abort strobe. The block counts pulses against a fixed limit. It detects an illegal program that would turn a 0 cell back into a 1, and holds that operation until the limit marks it failed. Reset commands from the host clear the error states. A failed operation needs the plain reset command. An aborted buffer program needs its own abort-reset command. The status word is registered: it changes on the clock edge that samples a read strobe hitting this bank.

Top module: `flash_op_status`

## Requirements
- R1: After reset `stat_data` is 0, `busy` is 0 and `susp_rd` is 0.
- R2: In a read mode (`busy`=0), a read hitting this bank loads `stat_data` with the `arr_data` sampled at that edge.
- R3: While `busy`=1, bits 6 and 2 of each captured status word are equal. The first read after a start returns TOG_INIT in both bits, and each later hit read returns the inverse of the previous one. A new start reloads TOG_INIT.
- R4: A read strobe whose `rd_bank` differs from BANK_ID leaves `stat_data` unchanged and does not advance the toggle sequence.
- R5: The busy status word has bit 7 equal to the inverse of bit 7 of the programmed word (0 for erase, `op_kind`=2), and bits 4, 3 and 0 are 0. Kind 1 is buffer program; kinds 0 and 3 program one word.
- R6: An `eng_done` strobe on a legal running operation drops `busy` at the next edge. The following read returns array data.
- R7: The PULSE_LIMIT-th `eng_pulse` of an operation sets the failed state: `busy` stays 1 and the status word shows bit 5 = 1. This takes priority over an `eng_done` in the same cycle.
- R8: A program whose word has a 1 where `arr_data` held 0 at start ignores `eng_done` and runs until the pulse limit fails it. Erase is never flagged this way.
- R9: In the failed state only `cmd_reset` leaves it. It returns to erase-suspend read (`susp_rd`=1) if `op_esusp` was high at start, else to plain read. `cmd_reset` has no effect while running or aborted.
- R10: `eng_bufabort` during a buffer program sets status bit 1, which holds until `cmd_abrst` returns the bank to plain read. The abort strobe is ignored for other kinds, and `cmd_abrst` is ignored outside the aborted state.
- R11: `op_start` while `busy`=1 is ignored: data polling and the toggle sequence continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_start | input | 1 | Start pulse for an embedded operation |
| op_kind | input | 2 | 0/3 word program, 1 buffer program, 2 erase |
| op_wdata | input | 8 | Word being programmed |
| op_esusp | input | 1 | High when the operation starts under erase suspend |
| arr_data | input | 8 | Array word at the addressed location |
| eng_pulse | input | 1 | One strobe per engine pulse |
| eng_done | input | 1 | Engine completion strobe |
| eng_bufabort | input | 1 | Engine buffer-abort strobe |
| rd_stb | input | 1 | Status read strobe |
| rd_bank | input | BANK_W | Bank addressed by the read |
| cmd_reset | input | 1 | Reset command |
| cmd_abrst | input | 1 | Buffer-abort reset command |
| stat_data | output | 8 | Registered status or array word |
| busy | output | 1 | Bank is not in a read mode |
| susp_rd | output | 1 | Bank is in erase-suspend read |

## Verification
The pulse that reaches the limit can arrive on the same edge as a status read of this bank. It can also arrive on the same edge as a completion strobe. The bench drives both collisions. On the read collision, the captured word must still show bit 5 clear, because it samples the flags ahead of the update. The toggle still advances, and the next read must show bit 5 set with the opposite toggle value. On the completion collision, `busy` must stay high and bit 5 must read 1, which shows that the failure wins.

// File: rtl/fos_pkg.sv
package fos_pkg;
  typedef enum logic [2:0] {
    ST_READ  = 3'd0,
    ST_SREAD = 3'd1,
    ST_BUSY  = 3'd2,
    ST_FAIL  = 3'd3,
    ST_ABORT = 3'd4
  } fos_state_e;

  localparam logic [1:0] KIND_BUF   = 2'd1;
  localparam logic [1:0] KIND_ERASE = 2'd2;
endpackage

// File: rtl/fos_pulse_cnt.sv
module fos_pulse_cnt #(
  parameter int PULSE_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic eng_pulse,
  output logic limit_hit
);
  localparam int CW = $clog2(PULSE_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(PULSE_LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en    = clr | (en & eng_pulse);
    cnt_d     = clr ? '0 : cnt_q + 1'b1;
    limit_hit = en & eng_pulse & (cnt_q == LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= LAST));
endmodule

// File: rtl/fos_toggle.sv
module fos_toggle #(
  parameter logic TOG_INIT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic adv,
  output logic tog
);
  logic tog_q, tog_d, tog_en;

  always_comb begin
    tog_en = load | adv;
    tog_d  = load ? TOG_INIT : ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= TOG_INIT;
    else if (tog_en) tog_q <= tog_d;
  end

  assign tog = tog_q;

  p_tog_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (tog == TOG_INIT));
endmodule

// File: rtl/fos_ctrl.sv
module fos_ctrl
  import fos_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_start,
  input  logic [1:0] op_kind,
  input  logic [7:0] op_wdata,
  input  logic       op_esusp,
  input  logic [7:0] arr_data,
  input  logic       eng_done,
  input  logic       eng_bufabort,
  input  logic       limit_hit,
  input  logic       cmd_reset,
  input  logic       cmd_abrst,
  output fos_state_e state,
  output logic       dpoll,
  output logic       start_ok
);
  fos_state_e st_q, st_d;
  logic buf_q, stall_q, susp_q, dpoll_q;
  logic buf_d, stall_d, susp_d, dpoll_d;
  logic is_erase;

  always_comb begin
    is_erase = (op_kind == KIND_ERASE);
    start_ok = op_start & ((st_q == ST_READ) | (st_q == ST_SREAD));
    buf_d    = (op_kind == KIND_BUF);
    stall_d  = ~is_erase & (|(op_wdata & ~arr_data));
    susp_d   = op_esusp;
    dpoll_d  = is_erase ? 1'b0 : ~op_wdata[7];
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_READ, ST_SREAD: if (start_ok) st_d = ST_BUSY;
      ST_BUSY: begin
        if (limit_hit)                   st_d = ST_FAIL;
        else if (eng_bufabort && buf_q)  st_d = ST_ABORT;
        else if (eng_done && !stall_q)   st_d = susp_q ? ST_SREAD : ST_READ;
      end
      ST_FAIL:  if (cmd_reset) st_d = susp_q ? ST_SREAD : ST_READ;
      ST_ABORT: if (cmd_abrst) st_d = ST_READ;
      default:  st_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_READ;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= 1'b0;
      stall_q <= 1'b0;
      susp_q  <= 1'b0;
      dpoll_q <= 1'b0;
    end else if (start_ok) begin
      buf_q   <= buf_d;
      stall_q <= stall_d;
      susp_q  <= susp_d;
      dpoll_q <= dpoll_d;
    end
  end

  assign state = st_q;
  assign dpoll = dpoll_q;

  p_limit_fails_r7: assert property (@(posedge clk) disable iff (!rst_n)
    limit_hit |=> (st_q == ST_FAIL));
  p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_BUSY && stall_q && eng_done) |=>
      (st_q != ST_READ && st_q != ST_SREAD));
  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAIL && !cmd_reset) |=> (st_q == ST_FAIL));
  p_abort_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ABORT && !cmd_abrst) |=> (st_q == ST_ABORT));
endmodule

// File: rtl/fos_word.sv
module fos_word (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap,
  input  logic       active,
  input  logic [7:0] arr_data,
  input  logic       dpoll,
  input  logic       tog,
  input  logic       fail,
  input  logic       abort,
  output logic [7:0] word
);
  logic [7:0] word_q, word_d;

  always_comb begin
    if (active) word_d = {dpoll, tog, fail, 2'b00, tog, abort, 1'b0};
    else        word_d = arr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   word_q <= '0;
    else if (cap) word_q <= word_d;
  end

  assign word = word_q;
endmodule

// File: rtl/flash_op_status.sv
module flash_op_status
  import fos_pkg::*;
#(
  parameter int   BANK_W      = 2,
  parameter int   BANK_ID     = 0,
  parameter int   PULSE_LIMIT = 16,
  parameter logic TOG_INIT    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic [7:0]        op_wdata,
  input  logic              op_esusp,
  input  logic [7:0]        arr_data,
  input  logic              eng_pulse,
  input  logic              eng_done,
  input  logic              eng_bufabort,
  input  logic              rd_stb,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic              cmd_reset,
  input  logic              cmd_abrst,
  output logic [7:0]        stat_data,
  output logic              busy,
  output logic              susp_rd
);
  localparam logic [BANK_W-1:0] OWN_BANK = BANK_W'(BANK_ID);

  fos_state_e state;
  logic dpoll, start_ok, limit_hit, tog;
  logic rd_hit, active, in_busy;

  always_comb begin
    rd_hit  = rd_stb & (rd_bank == OWN_BANK);
    in_busy = (state == ST_BUSY);
    active  = in_busy | (state == ST_FAIL) | (state == ST_ABORT);
  end

  fos_ctrl u_ctrl (
    .clk, .rst_n, .op_start, .op_kind, .op_wdata, .op_esusp, .arr_data,
    .eng_done, .eng_bufabort, .limit_hit, .cmd_reset, .cmd_abrst,
    .state, .dpoll, .start_ok
  );

  fos_pulse_cnt #(.PULSE_LIMIT(PULSE_LIMIT)) u_cnt (
    .clk, .rst_n, .clr(start_ok), .en(in_busy), .eng_pulse, .limit_hit
  );

  fos_toggle #(.TOG_INIT(TOG_INIT)) u_tog (
    .clk, .rst_n, .load(start_ok), .adv(rd_hit & active), .tog
  );

  fos_word u_word (
    .clk, .rst_n, .cap(rd_hit), .active, .arr_data, .dpoll, .tog,
    .fail(state == ST_FAIL), .abort(state == ST_ABORT), .word(stat_data)
  );

  assign busy    = active;
  assign susp_rd = (state == ST_SREAD);

  p_idle_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !busy) |=> (stat_data == $past(arr_data)));
  p_foreign_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_hit) |=> $stable(stat_data));
  p_tog_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && busy) |=> (stat_data[6] == stat_data[2]));
  p_reset_leaves_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAIL && cmd_reset) |=> !busy);
endmodule

// File: tb/test_flash_op_status.sv
module test_flash_op_status;
  localparam int   BW   = 2;
  localparam int   ID   = 1;
  localparam int   LIM  = 4;
  localparam logic TINI = 1'b1;
  localparam logic [BW-1:0] OWN = BW'(ID);
  localparam logic [BW-1:0] OTH = BW'(2);

  logic clk = 1'b0;
  logic rst_n;
  logic op_start, op_esusp, eng_pulse, eng_done, eng_bufabort;
  logic rd_stb, cmd_reset, cmd_abrst;
  logic [1:0] op_kind;
  logic [7:0] op_wdata, arr_data, stat_data;
  logic [BW-1:0] rd_bank;
  logic busy, susp_rd;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  flash_op_status #(.BANK_W(BW), .BANK_ID(ID), .PULSE_LIMIT(LIM),
                    .TOG_INIT(TINI)) i_flash_op_status (
    .clk, .rst_n, .op_start, .op_kind, .op_wdata, .op_esusp, .arr_data,
    .eng_pulse, .eng_done, .eng_bufabort, .rd_stb, .rd_bank,
    .cmd_reset, .cmd_abrst, .stat_data, .busy, .susp_rd
  );

  function automatic logic [7:0] bw(logic d7, logic t, logic f, logic a);
    return {d7, t, f, 2'b00, t, a, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic start(input logic [1:0] k, input logic [7:0] w,
                       input logic es);
    op_start = 1'b1; op_kind = k; op_wdata = w; op_esusp = es;
    @(negedge clk);
    op_start = 1'b0; op_esusp = 1'b0;
  endtask

  task automatic rd(input logic [BW-1:0] b);
    rd_stb = 1'b1; rd_bank = b;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      eng_pulse = 1'b1; @(negedge clk); eng_pulse = 1'b0;
    end
  endtask

  task automatic done();
    eng_done = 1'b1; @(negedge clk); eng_done = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic t;
    logic [7:0] e;
    rst_n = 1'b0;
    {op_start, op_esusp, eng_pulse, eng_done, eng_bufabort} = '0;
    {rd_stb, cmd_reset, cmd_abrst} = '0;
    op_kind = '0; op_wdata = '0; arr_data = '0; rd_bank = '0;
    repeat (3) @(negedge clk);
    chk("R1 stat", stat_data, 0);
    chk("R1 busy", busy, 0);
    chk("R1 susp", susp_rd, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R4: idle array echo across all values, foreign reads ignored
    for (int v = 0; v < 256; v++) begin
      arr_data = 8'(v);
      rd(OWN);
      chk("R2 echo", stat_data, v);
      arr_data = 8'(v) ^ 8'hA5;
      rd(OTH);
      chk("R4 idle foreign", stat_data, v);
    end

    // R3 / R4 / R5 / R6: program sweep over every data word
    for (int w = 0; w < 256; w++) begin
      arr_data = 8'hFF;
      start(2'd0, 8'(w), 1'b0);
      t = TINI;
      rd(OWN); e = bw(~w[7], t, 0, 0); chk("R3 R5 first", stat_data, e); t = ~t;
      rd(OWN); e = bw(~w[7], t, 0, 0); chk("R3 R5 second", stat_data, e); t = ~t;
      rd(OTH); chk("R4 busy foreign", stat_data, e);
      rd(OWN); chk("R3 R4 resume", stat_data, bw(~w[7], t, 0, 0));
      done();
      chk("R6 busy low", busy, 0);
      arr_data = 8'(w);
      rd(OWN); chk("R6 array after", stat_data, w);
    end

    // R11: start while busy ignored; R5 erase polls 0
    arr_data = 8'hFF;
    start(2'd0, 8'h00, 1'b0);
    t = TINI;
    rd(OWN); t = ~t;
    start(2'd2, 8'hFF, 1'b0);
    rd(OWN); chk("R11 start ignored", stat_data, bw(1'b1, t, 0, 0));
    done();
    start(2'd2, 8'h00, 1'b0);
    rd(OWN); chk("R5 erase word", stat_data, bw(1'b0, TINI, 0, 0));
    pulses(LIM - 1);
    rd(OWN); chk("R7 below limit", stat_data, bw(1'b0, ~TINI, 0, 0));
    done();
    chk("R6 erase done", busy, 0);

    // R7: limit pulse collides with a read
    start(2'd0, 8'h7F, 1'b0);
    pulses(LIM - 1);
    eng_pulse = 1'b1; rd_stb = 1'b1; rd_bank = OWN;
    @(negedge clk);
    eng_pulse = 1'b0; rd_stb = 1'b0;
    chk("R7 collide read", stat_data, bw(1'b1, TINI, 0, 0));
    rd(OWN); chk("R7 fail bit", stat_data, bw(1'b1, ~TINI, 1, 0));
    chk("R7 busy held", busy, 1);
    cmd_abrst = 1'b1; @(negedge clk); cmd_abrst = 1'b0;
    chk("R10 abrst ignored in fail", busy, 1);
    cmd_reset = 1'b1; @(negedge clk); cmd_reset = 1'b0;
    chk("R9 reset to read", busy, 0);
    chk("R9 plain read", susp_rd, 0);

    // R7: limit pulse collides with done
    start(2'd2, 8'h00, 1'b0);
    pulses(LIM - 1);
    eng_pulse = 1'b1; eng_done = 1'b1;
    @(negedge clk);
    eng_pulse = 1'b0; eng_done = 1'b0;
    chk("R7 limit beats done", busy, 1);
    rd(OWN); chk("R7 erase fail", stat_data, bw(1'b0, TINI, 1, 0));
    cmd_reset = 1'b1; @(negedge clk); cmd_reset = 1'b0;

    // R8: illegal 0->1 program stalls; R9 suspend return
    arr_data = 8'h0F;
    start(2'd0, 8'hF0, 1'b1);
    done();
    chk("R8 done ignored", busy, 1);
    rd(OWN); chk("R8 no fail yet", stat_data, bw(1'b0, TINI, 0, 0));
    cmd_reset = 1'b1; @(negedge clk); cmd_reset = 1'b0;
    chk("R9 reset ignored busy", busy, 1);
    pulses(LIM);
    rd(OWN); chk("R8 fail after limit", stat_data, bw(1'b0, ~TINI, 1, 0));
    cmd_reset = 1'b1; @(negedge clk); cmd_reset = 1'b0;
    chk("R9 suspend return", susp_rd, 1);
    chk("R9 busy low", busy, 0);
    start(2'd0, 8'h05, 1'b0);
    done();
    chk("R8 legal subset done", busy, 0);
    chk("R9 susp cleared", susp_rd, 0);

    // R10: buffer abort
    arr_data = 8'hFF;
    start(2'd1, 8'h80, 1'b0);
    eng_bufabort = 1'b1; @(negedge clk); eng_bufabort = 1'b0;
    rd(OWN); chk("R10 abort bit", stat_data, bw(1'b0, TINI, 0, 1));
    cmd_reset = 1'b1; @(negedge clk); cmd_reset = 1'b0;
    pulses(LIM);
    rd(OWN); chk("R10 abort held", stat_data, bw(1'b0, ~TINI, 0, 1));
    cmd_abrst = 1'b1; @(negedge clk); cmd_abrst = 1'b0;
    chk("R10 abrst exits", busy, 0);
    chk("R10 plain read", susp_rd, 0);
    start(2'd0, 8'h80, 1'b0);
    eng_bufabort = 1'b1; @(negedge clk); eng_bufabort = 1'b0;
    rd(OWN); chk("R10 word abort ignored", stat_data, bw(1'b0, TINI, 0, 0));
    done();
    chk("R10 word completes", busy, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule